// File: doc/BRIEF.md
# Virtual Address Translator with Fault Capture

This block maps a 16-bit virtual address onto an 18-bit or 22-bit physical address for one of three processor run modes. The top three address bits choose one of eight pages. The block reports the run mode, the page and the instruction/data space it needs. An external mapping register file answers in the same cycle with that page's base register and descriptor. The block adds the page base, scaled by 64, to the 13-bit offset within the page. It checks the descriptor's access code and its page length, and flags word accesses at odd addresses.

Every request gets a registered response one clock later. The response carries the physical address, an abort flag and a one-cycle strobe that names the trap vector, 4 or 250 (octal). When a write faults, the block also asks the register file to mark that page's descriptor as trapped.

The block owns a 16-bit fault status register. On the first fault after the error bits were cleared, it records the fault kind, the run mode, the page and the space. The register then stays frozen until software clears it. Software writes to this register follow masking rules. The block also derives the base of the I/O page from the mapping state.

Top module: `mmu_xlate_top`

## Requirements
- R1: When mapping applies, the physical address is the selected base register times 64 plus virtual address bits 12:0. The page number is virtual address bits 15:13.
- R2: Mapping applies when status bit 0 is 1, or for writes alone when status bit 8 is 1. Otherwise the physical address equals the zero-extended virtual address, and no access or length fault is raised.
- R3: With extension control bit 4 at 0, the physical address is cut to its low 18 bits. With bit 4 at 1, all 22 bits are kept.
- R4: A data-space request uses the data-space mappings only if the run mode's enable bit is set. Run mode 0 (kernel) uses extension control bit 2, mode 1 (supervisor) uses bit 1, and mode 3 (user) uses bit 0. Mode 2 never uses data space. The chosen space appears on `lk_dspace_o` in the same cycle.
- R5: Descriptor bits 2:0 hold the access code. Codes 0 and 4 abort as non-resident, with trap vector 4. Any other write whose code is not 6 aborts as read-only, with trap vector 250. Non-resident takes priority.
- R6: The length check compares virtual address bits 12:6 with descriptor bits 14:8. When descriptor bit 3 is 0 (growing up), the access aborts if the block number is above the length. When bit 3 is 1 (growing down), it aborts if the block number is below the length. Trap vector is 250. The check runs only if the access check passed.
- R7: A word access (`req_byte_i` = 0) at an odd address aborts with trap vector 4, whether or not mapping applies. It takes priority over all other faults and is not recorded in the status register.
- R8: An access, read-only or length fault updates the status register only while status bits 15:13 are all 0. A non-resident fault sets bit 15, a length fault sets bit 14, and a faulting write with an access code other than 6 sets bit 13. The capture also writes the mode into bits 6:5, the page into bits 3:1 and the chosen space into bit 4, and clears bit 12.
- R9: A faulting write pulses `set_trap_o` together with the mode, page and space of the access. A faulting read does not.
- R10: On a software write, bits 11:10 of the value are forced to 0. If value bit 0 is 1, value bits 15:13 are cleared. If status bits 15:13 are not all 0 and value bit 0 is 0, only value bits 7:1 are stored.
- R11: The I/O page base is 0160000 (octal) when status bit 0 is 0, 0760000 with 18-bit mapping and 017760000 with 22-bit mapping.
- R12: The response appears exactly one cycle after `req_i`, with `rsp_valid_o`, the trap strobes and `set_trap_o` lasting one cycle. The status capture lands on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Translation request, one cycle |
| req_va_i | input | 16 | Virtual address |
| req_wr_i | input | 1 | 1 for a write access |
| req_byte_i | input | 1 | 1 for a byte access |
| req_dspace_i | input | 1 | 1 for a data-space reference |
| req_mode_i | input | 2 | Run mode: 0 kernel, 1 supervisor, 3 user |
| ext_ctl_i | input | 5 | Extension control: bit 4 selects 22-bit, bits 2:0 enable data space |
| lk_mode_o | output | 2 | Run mode for the mapping lookup |
| lk_page_o | output | 3 | Page number for the mapping lookup |
| lk_dspace_o | output | 1 | Space for the mapping lookup |
| lk_par_i | input | 16 | Base register of the looked-up page |
| lk_pdr_i | input | 16 | Descriptor of the looked-up page |
| sw_we_i | input | 1 | Software write strobe for the status register |
| sw_wdata_i | input | 16 | Software write value |
| status_o | output | 16 | Fault status register |
| io_base_o | output | 22 | Physical base of the I/O page |
| rsp_valid_o | output | 1 | Response valid |
| rsp_pa_o | output | 22 | Physical address |
| rsp_abort_o | output | 1 | Access aborted |
| rsp_trap4_o | output | 1 | Trap to vector 4 |
| rsp_trap250_o | output | 1 | Trap to vector 250 |
| set_trap_o | output | 1 | Request to set the trapped bit of a descriptor |
| set_trap_mode_o | output | 2 | Mode of the descriptor to mark |
| set_trap_page_o | output | 3 | Page of the descriptor to mark |
| set_trap_dspace_o | output | 1 | Space of the descriptor to mark |

## Verification
The vector table drives the translator with several patterns:
- Plain in-range reads at different pages and base values show the base-plus-offset sum and the 18-bit and 22-bit cut.
- Each access code is tried with both reads and writes, which separates the non-resident and read-only outcomes.
- Block numbers one step either side of the length field, in both growth directions, place the inclusive edge of the length check.
- An odd address is tried with a byte access and with a word access, which isolates the alignment rule.

Directed sequences cover the rest:
- mapping off against maintenance mode, with a read and a write;
- one fault followed by a second fault, which shows that the status register freezes;
- every case of the software write masking;
- the three I/O base choices.

// File: rtl/mmu_xlate_pkg.sv
package mmu_xlate_pkg;
  localparam int ST_EN    = 0;
  localparam int ST_MAINT = 8;
  localparam int ST_NR    = 15;
  localparam int ST_LEN   = 14;
  localparam int ST_RO    = 13;
  localparam logic [15:0] ST_HOLE_MASK  = 16'h0C00;
  localparam logic [15:0] ST_PROT_KEEP  = 16'h00FE;
  localparam logic [15:0] ST_CAP_CLEAR  = 16'hF07E;
  localparam logic [2:0]  AC_RW         = 3'd6;

  typedef enum logic [1:0] {
    MODE_KERN = 2'd0,
    MODE_SUPV = 2'd1,
    MODE_RSVD = 2'd2,
    MODE_USER = 2'd3
  } run_mode_e;

  typedef struct packed {
    logic odd;
    logic nonres;
    logic rdonly;
    logic length;
  } fault_t;
endpackage

// File: rtl/mmu_dspace_sel.sv
module mmu_dspace_sel
  import mmu_xlate_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       dspace_i,
  input  logic [2:0] dsp_en_i,
  output logic       use_d_o
);
  logic mode_en;

  always_comb begin
    unique case (run_mode_e'(mode_i))
      MODE_KERN: mode_en = dsp_en_i[2];
      MODE_SUPV: mode_en = dsp_en_i[1];
      MODE_USER: mode_en = dsp_en_i[0];
      default:   mode_en = 1'b0;
    endcase
  end

  assign use_d_o = dspace_i & mode_en;
endmodule

// File: rtl/mmu_xlate_core.sv
module mmu_xlate_core
  import mmu_xlate_pkg::*;
#(
  parameter int VA_W      = 16,
  parameter int PAGE_W    = 3,
  parameter int BLK_SHIFT = 6,
  parameter int PA_W      = 22,
  parameter int PA_NARW_W = 18
) (
  input  logic [VA_W-1:0]           va_i,
  input  logic                      wr_i,
  input  logic                      byte_i,
  input  logic                      xlate_i,
  input  logic                      wide_i,
  input  logic [PA_W-BLK_SHIFT-1:0] par_i,
  input  logic [15:0]               pdr_i,
  output logic [PA_W-1:0]           pa_o,
  output fault_t                    flt_o
);
  localparam int OFF_W = VA_W - PAGE_W;
  localparam int BLK_W = OFF_W - BLK_SHIFT;

  logic [PA_W-1:0]  sum;
  logic [2:0]       ac;
  logic [BLK_W-1:0] blk, len;
  logic             dir_down, odd, nonres, wr_bad, acc_fail, len_bad;
  logic             unused_pdr;

  assign unused_pdr = ^{pdr_i[15], pdr_i[7:4]};

  assign sum = {par_i, {BLK_SHIFT{1'b0}}} + PA_W'(va_i[OFF_W-1:0]);

  always_comb begin
    if (!xlate_i)   pa_o = PA_W'(va_i);
    else if (wide_i) pa_o = sum;
    else            pa_o = PA_W'(sum[PA_NARW_W-1:0]);
  end

  assign ac       = pdr_i[2:0];
  assign blk      = va_i[OFF_W-1:BLK_SHIFT];
  assign len      = pdr_i[8+BLK_W-1:8];
  assign dir_down = pdr_i[3];

  assign odd      = ~byte_i & va_i[0];
  assign nonres   = xlate_i & (ac[1:0] == 2'b00);
  assign wr_bad   = xlate_i & wr_i & (ac != AC_RW);
  assign acc_fail = nonres | wr_bad;
  assign len_bad  = xlate_i & ~acc_fail & (dir_down ? (blk < len) : (blk > len));

  assign flt_o.odd    = odd;
  assign flt_o.nonres = ~odd & nonres;
  assign flt_o.rdonly = ~odd & wr_bad;
  assign flt_o.length = ~odd & len_bad;
endmodule

// File: rtl/mmu_fault_status.sv
module mmu_fault_status
  import mmu_xlate_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_we_i,
  input  logic [15:0]       sw_wdata_i,
  input  logic              cap_i,
  input  logic              nonres_i,
  input  logic              rdonly_i,
  input  logic              length_i,
  input  logic [1:0]        mode_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              dspace_i,
  output logic [15:0]       status_o
);
  logic [15:0] st_q, sw_val, cap_val;
  logic        locked;

  assign locked = |st_q[ST_NR:ST_RO];

  always_comb begin
    sw_val = sw_wdata_i & ~ST_HOLE_MASK;
    if (sw_val[ST_EN]) sw_val[ST_NR:ST_RO] = 3'b000;
    if (locked && !sw_val[ST_EN]) sw_val = sw_val & ST_PROT_KEEP;
  end

  always_comb begin
    cap_val           = st_q & ~ST_CAP_CLEAR;
    cap_val[ST_NR]    = nonres_i;
    cap_val[ST_LEN]   = length_i;
    cap_val[ST_RO]    = rdonly_i;
    cap_val[6:5]      = mode_i;
    cap_val[4]        = dspace_i;
    cap_val[PAGE_W:1] = page_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                st_q <= '0;
    else if (sw_we_i)           st_q <= sw_val;
    else if (cap_i && !locked)  st_q <= cap_val;
  end

  assign status_o = st_q;
endmodule

// File: rtl/mmu_xlate_top.sv
module mmu_xlate_top
  import mmu_xlate_pkg::*;
#(
  parameter int VA_W      = 16,
  parameter int PAGE_W    = 3,
  parameter int BLK_SHIFT = 6,
  parameter int PA_W      = 22,
  parameter int PA_NARW_W = 18
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic [VA_W-1:0]           req_va_i,
  input  logic                      req_wr_i,
  input  logic                      req_byte_i,
  input  logic                      req_dspace_i,
  input  logic [1:0]                req_mode_i,
  input  logic [4:0]                ext_ctl_i,
  output logic [1:0]                lk_mode_o,
  output logic [PAGE_W-1:0]         lk_page_o,
  output logic                      lk_dspace_o,
  input  logic [PA_W-BLK_SHIFT-1:0] lk_par_i,
  input  logic [15:0]               lk_pdr_i,
  input  logic                      sw_we_i,
  input  logic [15:0]               sw_wdata_i,
  output logic [15:0]               status_o,
  output logic [PA_W-1:0]           io_base_o,
  output logic                      rsp_valid_o,
  output logic [PA_W-1:0]           rsp_pa_o,
  output logic                      rsp_abort_o,
  output logic                      rsp_trap4_o,
  output logic                      rsp_trap250_o,
  output logic                      set_trap_o,
  output logic [1:0]                set_trap_mode_o,
  output logic [PAGE_W-1:0]         set_trap_page_o,
  output logic                      set_trap_dspace_o
);
  localparam int IO_SPAN_W = VA_W - PAGE_W;
  localparam logic [PA_W-1:0] IO_BASE_OFF  = PA_W'({PAGE_W{1'b1}}) << IO_SPAN_W;
  localparam logic [PA_W-1:0] IO_BASE_NARW = ((PA_W'(1) << PA_NARW_W) - 1) & ~((PA_W'(1) << IO_SPAN_W) - 1);
  localparam logic [PA_W-1:0] IO_BASE_WIDE = ~((PA_W'(1) << IO_SPAN_W) - 1);

  logic            use_d, xlate, any_flt, unused_ext;
  logic [PA_W-1:0] pa;
  fault_t          flt;

  assign unused_ext = ext_ctl_i[3];

  mmu_dspace_sel u_dsel (
    .mode_i   (req_mode_i),
    .dspace_i (req_dspace_i),
    .dsp_en_i (ext_ctl_i[2:0]),
    .use_d_o  (use_d)
  );

  assign lk_mode_o   = req_mode_i;
  assign lk_page_o   = req_va_i[VA_W-1 -: PAGE_W];
  assign lk_dspace_o = use_d;

  assign xlate = status_o[ST_EN] | (req_wr_i & status_o[ST_MAINT]);

  mmu_xlate_core #(
    .VA_W(VA_W), .PAGE_W(PAGE_W), .BLK_SHIFT(BLK_SHIFT),
    .PA_W(PA_W), .PA_NARW_W(PA_NARW_W)
  ) u_core (
    .va_i    (req_va_i),
    .wr_i    (req_wr_i),
    .byte_i  (req_byte_i),
    .xlate_i (xlate),
    .wide_i  (ext_ctl_i[4]),
    .par_i   (lk_par_i),
    .pdr_i   (lk_pdr_i),
    .pa_o    (pa),
    .flt_o   (flt)
  );

  mmu_fault_status #(.PAGE_W(PAGE_W)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_we_i    (sw_we_i),
    .sw_wdata_i (sw_wdata_i),
    .cap_i      (req_i & (flt.nonres | flt.rdonly | flt.length)),
    .nonres_i   (flt.nonres),
    .rdonly_i   (flt.rdonly),
    .length_i   (flt.length),
    .mode_i     (req_mode_i),
    .page_i     (lk_page_o),
    .dspace_i   (use_d),
    .status_o   (status_o)
  );

  always_comb begin
    if (!status_o[ST_EN])   io_base_o = IO_BASE_OFF;
    else if (ext_ctl_i[4])  io_base_o = IO_BASE_WIDE;
    else                    io_base_o = IO_BASE_NARW;
  end

  assign any_flt = flt.odd | flt.nonres | flt.rdonly | flt.length;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o       <= 1'b0;
      rsp_pa_o          <= '0;
      rsp_abort_o       <= 1'b0;
      rsp_trap4_o       <= 1'b0;
      rsp_trap250_o     <= 1'b0;
      set_trap_o        <= 1'b0;
      set_trap_mode_o   <= '0;
      set_trap_page_o   <= '0;
      set_trap_dspace_o <= 1'b0;
    end else begin
      rsp_valid_o   <= req_i;
      rsp_abort_o   <= req_i & any_flt;
      rsp_trap4_o   <= req_i & (flt.odd | flt.nonres);
      rsp_trap250_o <= req_i & ~(flt.odd | flt.nonres) & (flt.rdonly | flt.length);
      set_trap_o    <= req_i & req_wr_i & any_flt;
      if (req_i) begin
        rsp_pa_o          <= pa;
        set_trap_mode_o   <= req_mode_i;
        set_trap_page_o   <= lk_page_o;
        set_trap_dspace_o <= use_d;
      end
    end
  end
endmodule

// File: rtl/mmu_xlate_checker.sv
module mmu_xlate_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        sw_we_i,
  input logic [15:0] sw_wdata_i,
  input logic [15:0] status_o,
  input logic        rsp_valid_o,
  input logic        rsp_abort_o,
  input logic        rsp_trap4_o,
  input logic        rsp_trap250_o,
  input logic        set_trap_o
);
  assert_rsp_follows_req_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  assert_rsp_one_cycle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  assert_trap_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_trap4_o |-> !rsp_trap250_o);
  assert_trap_implies_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_trap4_o || rsp_trap250_o) |-> (rsp_abort_o && rsp_valid_o));
  assert_set_trap_on_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_trap_o |-> rsp_abort_o);
  assert_status_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|status_o[15:13]) && !sw_we_i) |=> $stable(status_o));
  assert_hole_bits_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[11:10] == 2'b00);
  assert_enable_clears_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && sw_wdata_i[0]) |=> (status_o[15:13] == 3'b000));
endmodule

bind mmu_xlate_top mmu_xlate_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .sw_we_i       (sw_we_i),
  .sw_wdata_i    (sw_wdata_i),
  .status_o      (status_o),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_abort_o   (rsp_abort_o),
  .rsp_trap4_o   (rsp_trap4_o),
  .rsp_trap250_o (rsp_trap250_o),
  .set_trap_o    (set_trap_o)
);

// File: tb/mmu_xlate_top_test.sv
`timescale 1ns/1ps
module mmu_xlate_top_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [15:0] req_va_i = '0;
  logic        req_wr_i = 1'b0, req_byte_i = 1'b0, req_dspace_i = 1'b0;
  logic [1:0]  req_mode_i = '0;
  logic [4:0]  ext_ctl_i = '0;
  logic [1:0]  lk_mode_o;
  logic [2:0]  lk_page_o;
  logic        lk_dspace_o;
  logic [15:0] lk_par_i = '0, lk_pdr_i = '0;
  logic        sw_we_i = 1'b0;
  logic [15:0] sw_wdata_i = '0;
  logic [15:0] status_o;
  logic [21:0] io_base_o, rsp_pa_o;
  logic        rsp_valid_o, rsp_abort_o, rsp_trap4_o, rsp_trap250_o;
  logic        set_trap_o, set_trap_dspace_o;
  logic [1:0]  set_trap_mode_o;
  logic [2:0]  set_trap_page_o;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  mmu_xlate_top uut (.*, .clk_i(clk));

  typedef struct packed {
    logic [15:0] va;
    logic        wr;
    logic        byt;
    logic [15:0] par;
    logic [15:0] pdr;
    logic [4:0]  ext;
    logic [21:0] pa;
    logic        ab;
    logic        t4;
    logic        t250;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{16'h2040, 1'b0, 1'b0, 16'h0100, 16'h7F06, 5'h00, 22'h004040, 1'b0, 1'b0, 1'b0}, // R1
    '{16'h0010, 1'b0, 1'b0, 16'hFF00, 16'h7F06, 5'h10, 22'h3FC010, 1'b0, 1'b0, 1'b0}, // R3 wide
    '{16'h0010, 1'b0, 1'b0, 16'hFF00, 16'h7F06, 5'h00, 22'h03C010, 1'b0, 1'b0, 1'b0}, // R3 narrow
    '{16'h4000, 1'b0, 1'b0, 16'h0200, 16'h7F00, 5'h00, 22'h000000, 1'b1, 1'b1, 1'b0}, // R5 ac0
    '{16'h4000, 1'b0, 1'b0, 16'h0200, 16'h7F04, 5'h00, 22'h000000, 1'b1, 1'b1, 1'b0}, // R5 ac4
    '{16'h4000, 1'b1, 1'b0, 16'h0200, 16'h7F02, 5'h00, 22'h000000, 1'b1, 1'b0, 1'b1}, // R5 wr ac2
    '{16'h4000, 1'b0, 1'b0, 16'h0200, 16'h7F02, 5'h00, 22'h008000, 1'b0, 1'b0, 1'b0}, // R5 rd ac2
    '{16'h4000, 1'b1, 1'b0, 16'h0200, 16'h7F06, 5'h00, 22'h008000, 1'b0, 1'b0, 1'b0}, // R5 wr ac6
    '{16'h2080, 1'b0, 1'b0, 16'h0000, 16'h0106, 5'h00, 22'h000000, 1'b1, 1'b0, 1'b1}, // R6 up over
    '{16'h2040, 1'b0, 1'b0, 16'h0000, 16'h0106, 5'h00, 22'h000040, 1'b0, 1'b0, 1'b0}, // R6 up edge
    '{16'h3F40, 1'b0, 1'b0, 16'h0000, 16'h7E0E, 5'h00, 22'h000000, 1'b1, 1'b0, 1'b1}, // R6 down under
    '{16'h3F80, 1'b0, 1'b0, 16'h0000, 16'h7E0E, 5'h00, 22'h001F80, 1'b0, 1'b0, 1'b0}, // R6 down edge
    '{16'h2041, 1'b0, 1'b0, 16'h0100, 16'h7F06, 5'h00, 22'h000000, 1'b1, 1'b1, 1'b0}, // R7 odd word
    '{16'h2041, 1'b0, 1'b1, 16'h0100, 16'h7F06, 5'h00, 22'h004041, 1'b0, 1'b0, 1'b0}, // R7 odd byte
    '{16'h2080, 1'b1, 1'b0, 16'h0000, 16'h0101, 5'h00, 22'h000000, 1'b1, 1'b0, 1'b1}  // R5 wr ac1
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] m, input logic d, input logic [15:0] va,
                        input logic wr, input logic byt, input logic [15:0] par,
                        input logic [15:0] pdr, input logic [4:0] ext);
    @(negedge clk);
    req_i = 1'b1; req_mode_i = m; req_dspace_i = d; req_va_i = va;
    req_wr_i = wr; req_byte_i = byt; lk_par_i = par; lk_pdr_i = pdr; ext_ctl_i = ext;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic sw_wr(input logic [15:0] v);
    @(negedge clk);
    sw_we_i = 1'b1; sw_wdata_i = v;
    @(negedge clk);
    sw_we_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset state
    chk("R12 reset valid", rsp_valid_o, 0);
    chk("R8 reset status", status_o, 0);
    chk("R11 io base off", io_base_o, 22'h00E000);

    // R2 mapping off: identity, no fault even with ac 0
    do_req(0, 0, 16'h4000, 0, 0, 16'h0200, 16'h7F00, 5'h00);
    chk("R2 off pa", rsp_pa_o, 22'h004000);
    chk("R2 off abort", rsp_abort_o, 0);
    chk("R12 valid", rsp_valid_o, 1);
    @(negedge clk);
    chk("R12 one cycle", rsp_valid_o, 0);

    // R2 maintenance mode
    sw_wr(16'h0100);
    do_req(0, 0, 16'h2040, 1, 0, 16'h0100, 16'h7F06, 5'h00);
    chk("R2 maint write", rsp_pa_o, 22'h004040);
    do_req(0, 0, 16'h2040, 0, 0, 16'h0100, 16'h7F06, 5'h00);
    chk("R2 maint read", rsp_pa_o, 22'h002040);

    // table
    sw_wr(16'h0001);
    for (int i = 0; i < NV; i++) begin
      do_req(0, 0, VEC[i].va, VEC[i].wr, VEC[i].byt, VEC[i].par, VEC[i].pdr, VEC[i].ext);
      if (!VEC[i].ab) chk($sformatf("R1 vec%0d pa", i), rsp_pa_o, VEC[i].pa);
      chk($sformatf("R5 vec%0d abort", i), rsp_abort_o, VEC[i].ab);
      chk($sformatf("R7 vec%0d trap4", i), rsp_trap4_o, VEC[i].t4);
      chk($sformatf("R6 vec%0d trap250", i), rsp_trap250_o, VEC[i].t250);
    end

    // R4 space selection
    @(negedge clk);
    req_mode_i = 2'd3; req_dspace_i = 1'b1; ext_ctl_i = 5'h01; #1;
    chk("R4 user d on", lk_dspace_o, 1);
    ext_ctl_i = 5'h06; #1;
    chk("R4 user d off", lk_dspace_o, 0);
    req_mode_i = 2'd0; ext_ctl_i = 5'h04; #1;
    chk("R4 kernel d", lk_dspace_o, 1);
    req_mode_i = 2'd1; ext_ctl_i = 5'h02; #1;
    chk("R4 super d", lk_dspace_o, 1);
    req_mode_i = 2'd2; ext_ctl_i = 5'h07; #1;
    chk("R4 mode2 no d", lk_dspace_o, 0);

    // R8/R9 capture
    sw_wr(16'h0001);
    chk("R10 clear", status_o, 16'h0001);
    do_req(3, 1, 16'hA000, 1, 0, 16'h0000, 16'h7F00, 5'h01);
    chk("R8 capture", status_o, 16'hA07B);
    chk("R9 set_trap", set_trap_o, 1);
    chk("R9 mode", set_trap_mode_o, 3);
    chk("R9 page", set_trap_page_o, 5);
    chk("R9 dspace", set_trap_dspace_o, 1);
    chk("R5 nonres trap4", rsp_trap4_o, 1);
    @(negedge clk);
    chk("R12 strobe one cycle", set_trap_o, 0);
    do_req(0, 0, 16'h2080, 0, 0, 16'h0000, 16'h0106, 5'h00);
    chk("R8 frozen", status_o, 16'hA07B);
    chk("R9 read no set_trap", set_trap_o, 0);
    chk("R6 len trap", rsp_trap250_o, 1);

    // R10 software writes
    sw_wr(16'h0CFE);
    chk("R10 protected", status_o, 16'h00FE);
    sw_wr(16'hFFFE);
    chk("R10 unlocked", status_o, 16'hF3FE);
    sw_wr(16'hEC01);
    chk("R10 enable clears", status_o, 16'h0001);

    // R11 io base
    ext_ctl_i = 5'h00; #1;
    chk("R11 io 18", io_base_o, 22'h03E000);
    ext_ctl_i = 5'h10; #1;
    chk("R11 io 22", io_base_o, 22'h3FE000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule